// File: doc/BRIEF.md
# Protection Fault Delay and Output Controller

This block sits behind the analog comparators of a battery-pack protection chip. For each monitored cell condition (cell overvoltage, cell undervoltage, a disconnected sense wire, and an overheated pack) it receives two flags. One flag says the condition has been detected. The other says its hysteretic recovery condition has been met. A condition becomes a declared fault only after it has held for a selectable delay, counted in millisecond ticks. Any recovery seen before that point cancels the timer. A fifth source, the oscillator health monitor, bypasses the delay and acts at once.

Declared faults pass through a fixed matrix to two fault pins. One pin opens the charge path and the other opens the discharge path. Each pin has its own active polarity. A single mode output reports whether the block is in normal mode or fault mode. Per-fault enable bits remove a source entirely. A latch option makes every declared fault persist until the power-on reset. While a test request is held, a short fixed delay replaces every selected delay, which speeds up production testing.

Top module: `prot_fault_ctrl`

## Requirements
- R1: A detected, enabled timed fault (overvoltage, undervoltage, open wire, overtemperature) is declared when its timer has counted as many `ms_tick` pulses as its delay; its outputs stay inactive before that, and cycles without `ms_tick` do not advance the timer.
- R2: Each timed fault has a 3-bit delay select: 0 gives 250 ms, 1 gives 500 ms, 2 gives 1000 ms, 3 gives 2000 ms, and 4 to 7 all give 4000 ms.
- R3: A recovery flag seen while a timer is running returns it to idle with no fault declared; a later detection needs the full delay again.
- R4: A declared overvoltage drives only the charge output, a declared undervoltage drives only the discharge output, and open wire or overtemperature drive both.
- R5: `osc_bad` drives both outputs active one clock after it is sampled, with no delay timer, and they go inactive one clock after it clears.
- R6: Without latching, a recovery flag on a declared fault makes its contribution inactive on the next clock; an output shared by several faults stays active while any of them is declared.
- R7: With `latch_en` high, declared faults (timed and oscillator) ignore recovery and clear only on reset.
- R8: An `*_act_high` bit of 1 makes that output drive 1 when active and 0 when inactive; a bit of 0 inverts both levels.
- R9: While `test_req` is high (registered, one clock of latency), every timed fault uses a 50 ms delay; after it drops, the selected delays apply again.
- R10: `fault_mode` is 1 exactly when at least one of the two outputs is at its active level.
- R11: `fault_en` bit 0 enables overvoltage, bit 1 undervoltage, bit 2 open wire, bit 3 overtemperature and bit 4 oscillator health; a cleared bit holds that source's timer idle and its contribution inactive.
- R12: During and right after reset both outputs sit at their inactive levels and `fault_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| ov_det | input | 1 | Overvoltage detected |
| ov_rec | input | 1 | Overvoltage recovery met |
| uv_det | input | 1 | Undervoltage detected |
| uv_rec | input | 1 | Undervoltage recovery met |
| ow_det | input | 1 | Open sense wire detected |
| ow_rec | input | 1 | Open wire recovery met |
| ot_det | input | 1 | Overtemperature detected |
| ot_rec | input | 1 | Overtemperature recovery met |
| osc_bad | input | 1 | Oscillator running too slow |
| test_req | input | 1 | Request short test delay |
| latch_en | input | 1 | Hold declared faults until reset |
| fault_en | input | 5 | Per-source enable bits |
| ov_dly_sel | input | 3 | Overvoltage delay select |
| uv_dly_sel | input | 3 | Undervoltage delay select |
| ow_dly_sel | input | 3 | Open wire delay select |
| ot_dly_sel | input | 3 | Overtemperature delay select |
| chg_act_high | input | 1 | Charge output active level |
| dsg_act_high | input | 1 | Discharge output active level |
| chg_out | output | 1 | Charge path fault output |
| dsg_out | output | 1 | Discharge path fault output |
| fault_mode | output | 1 | 1 in fault mode, 0 in normal mode |

## Verification
Timer state is hidden, so a timer that counts wrongly or keeps a stale count shows at the pins only as an output edge that comes too early or too late. The bench therefore samples the output one tick before and one tick after each expected declaration, so an off-by-one error is visible. A timer that fails to clear on recovery shows up only after a later re-detection, as an early declaration, and the bench checks for that there. A wrong routing entry or latch state shows on the pin on the clock after the declaration or recovery, and every check samples there.

// File: rtl/prot_fault_pkg.sv
package prot_fault_pkg;

    localparam int NUM_TIMED = 4;
    localparam int NUM_SRC   = NUM_TIMED + 1;
    localparam int SEL_W     = 3;

    localparam int IDX_OV  = 0;
    localparam int IDX_UV  = 1;
    localparam int IDX_OW  = 2;
    localparam int IDX_OT  = 3;
    localparam int IDX_OSC = 4;

    // Fault-to-output routing: bit i set means timed source i drives that output.
    localparam logic [NUM_TIMED-1:0] CHG_ROUTE = 4'b1101;
    localparam logic [NUM_TIMED-1:0] DSG_ROUTE = 4'b1110;

    typedef enum logic [1:0] {
        TM_IDLE = 2'd0,
        TM_RUN  = 2'd1,
        TM_HIT  = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/prot_delay_timer.sv
module prot_delay_timer
    import prot_fault_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             det_i,
    input  logic             rec_i,
    input  logic             latch_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             decl_o
);

    typedef struct packed {
        tmr_state_e       state;
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t r_d, r_q;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        r_d     = r_q;
        cnt_inc = {1'b0, r_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        if (!en_i) begin
            r_d.state = TM_IDLE;
            r_d.cnt   = '0;
        end else begin
            case (r_q.state)
                TM_IDLE: begin
                    r_d.cnt = '0;
                    if (det_i && !rec_i) begin
                        r_d.state = TM_RUN;
                    end
                end
                TM_RUN: begin
                    if (rec_i) begin
                        r_d.state = TM_IDLE;
                        r_d.cnt   = '0;
                    end else if (tick_i) begin
                        if (cnt_inc >= {1'b0, limit_i}) begin
                            r_d.state = TM_HIT;
                            r_d.cnt   = '0;
                        end else begin
                            r_d.cnt = cnt_inc[CNT_W-1:0];
                        end
                    end
                end
                TM_HIT: begin
                    if (rec_i && !latch_i) begin
                        r_d.state = TM_IDLE;
                    end
                end
                default: begin
                    r_d.state = TM_IDLE;
                    r_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: TM_IDLE, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign decl_o = (r_q.state == TM_HIT);

    // R1: a declaration only follows a running timer that saw a tick
    p_decl_after_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(decl_o) |-> ($past(r_q.state) == TM_RUN && $past(tick_i)));

    // R3: recovery while running cancels the timer
    p_rec_cancels_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && r_q.state == TM_RUN && rec_i) |=> (r_q.state == TM_IDLE));

    // R7: a latched declaration persists while enabled
    p_latch_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && latch_i && decl_o) |=> decl_o);

    // R11: a disabled source is idle on the next clock
    p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (r_q.state == TM_IDLE && r_q.cnt == '0));

endmodule

// File: rtl/prot_out_map.sv
module prot_out_map
    import prot_fault_pkg::*;
(
    input  logic [NUM_TIMED-1:0] decl_i,
    input  logic                 osc_i,
    input  logic                 chg_ah_i,
    input  logic                 dsg_ah_i,
    output logic                 chg_o,
    output logic                 dsg_o,
    output logic                 mode_o
);

    logic chg_act, dsg_act;

    always_comb begin
        chg_act = osc_i || ((decl_i & CHG_ROUTE) != '0);
        dsg_act = osc_i || ((decl_i & DSG_ROUTE) != '0);
        chg_o   = chg_act ? chg_ah_i : !chg_ah_i;
        dsg_o   = dsg_act ? dsg_ah_i : !dsg_ah_i;
        mode_o  = chg_act || dsg_act;
    end

endmodule

// File: rtl/prot_fault_ctrl.sv
module prot_fault_ctrl
    import prot_fault_pkg::*;
#(
    parameter int BASE_MS   = 250,
    parameter int NUM_STEPS = 5,
    parameter int TEST_MS   = 50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ms_tick,
    input  logic               ov_det,
    input  logic               ov_rec,
    input  logic               uv_det,
    input  logic               uv_rec,
    input  logic               ow_det,
    input  logic               ow_rec,
    input  logic               ot_det,
    input  logic               ot_rec,
    input  logic               osc_bad,
    input  logic               test_req,
    input  logic               latch_en,
    input  logic [NUM_SRC-1:0] fault_en,
    input  logic [SEL_W-1:0]   ov_dly_sel,
    input  logic [SEL_W-1:0]   uv_dly_sel,
    input  logic [SEL_W-1:0]   ow_dly_sel,
    input  logic [SEL_W-1:0]   ot_dly_sel,
    input  logic               chg_act_high,
    input  logic               dsg_act_high,
    output logic               chg_out,
    output logic               dsg_out,
    output logic               fault_mode
);

    localparam int MAX_MS = BASE_MS << (NUM_STEPS - 1);
    localparam int CNT_W  = $clog2(MAX_MS + 1);

    typedef struct packed {
        logic test;
        logic osc;
    } top_regs_t;

    top_regs_t r_d, r_q;

    logic [NUM_TIMED-1:0] det_v, rec_v, decl_v;
    logic [SEL_W-1:0]     sel_v [NUM_TIMED];

    assign det_v = {ot_det, ow_det, uv_det, ov_det};
    assign rec_v = {ot_rec, ow_rec, uv_rec, ov_rec};
    assign sel_v[IDX_OV] = ov_dly_sel;
    assign sel_v[IDX_UV] = uv_dly_sel;
    assign sel_v[IDX_OW] = ow_dly_sel;
    assign sel_v[IDX_OT] = ot_dly_sel;

    function automatic logic [CNT_W-1:0] sel_limit(input logic [SEL_W-1:0] s);
        if (int'(s) >= NUM_STEPS - 1) begin
            return CNT_W'(MAX_MS);
        end
        return CNT_W'(BASE_MS) << s;
    endfunction

    always_comb begin
        r_d      = r_q;
        r_d.test = test_req;
        if (!fault_en[IDX_OSC]) begin
            r_d.osc = 1'b0;
        end else if (osc_bad) begin
            r_d.osc = 1'b1;
        end else if (!latch_en) begin
            r_d.osc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{test: 1'b0, osc: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar g = 0; g < NUM_TIMED; g++) begin : g_tmr
        logic [CNT_W-1:0] limit_g;
        assign limit_g = r_q.test ? CNT_W'(TEST_MS) : sel_limit(sel_v[g]);

        prot_delay_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (ms_tick),
            .en_i    (fault_en[g]),
            .det_i   (det_v[g]),
            .rec_i   (rec_v[g]),
            .latch_i (latch_en),
            .limit_i (limit_g),
            .decl_o  (decl_v[g])
        );
    end

    prot_out_map u_map (
        .decl_i   (decl_v),
        .osc_i    (r_q.osc),
        .chg_ah_i (chg_act_high),
        .dsg_ah_i (dsg_act_high),
        .chg_o    (chg_out),
        .dsg_o    (dsg_out),
        .mode_o   (fault_mode)
    );

    // R5: oscillator fault reaches both pins one clock later
    p_osc_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_bad && fault_en[IDX_OSC]) |=>
            (chg_out == chg_act_high && dsg_out == dsg_act_high));

    // R10: mode indication agrees with the pin levels
    p_mode_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_mode == ((chg_out == chg_act_high) || (dsg_out == dsg_act_high)));

    // R4: an overvoltage alone leaves the discharge pin inactive
    p_ov_chg_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (decl_v == 4'b0001 && !r_q.osc) |-> (dsg_out != dsg_act_high && chg_out == chg_act_high));

    // R12: pins idle right after reset
    p_reset_idle_r12: assert property (@(posedge clk)
        $rose(rst_n) |-> !fault_mode);

endmodule

// File: tb/prot_fault_ctrl_tb.sv
module prot_fault_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b1;
    logic ov_det = 0, ov_rec = 0, uv_det = 0, uv_rec = 0;
    logic ow_det = 0, ow_rec = 0, ot_det = 0, ot_rec = 0;
    logic osc_bad = 0, test_req = 0, latch_en = 0;
    logic [4:0] fault_en = 5'b11111;
    logic [2:0] ov_dly_sel = 0, uv_dly_sel = 0, ow_dly_sel = 0, ot_dly_sel = 0;
    logic chg_act_high = 1'b1, dsg_act_high = 1'b0;
    logic chg_out, dsg_out, fault_mode;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_fault_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .ov_det(ov_det), .ov_rec(ov_rec), .uv_det(uv_det), .uv_rec(uv_rec),
        .ow_det(ow_det), .ow_rec(ow_rec), .ot_det(ot_det), .ot_rec(ot_rec),
        .osc_bad(osc_bad), .test_req(test_req), .latch_en(latch_en),
        .fault_en(fault_en), .ov_dly_sel(ov_dly_sel), .uv_dly_sel(uv_dly_sel),
        .ow_dly_sel(ow_dly_sel), .ot_dly_sel(ot_dly_sel),
        .chg_act_high(chg_act_high), .dsg_act_high(dsg_act_high),
        .chg_out(chg_out), .dsg_out(dsg_out), .fault_mode(fault_mode)
    );

    // Expected {chg_out, dsg_out, fault_mode} from which paths should be active.
    function automatic logic [2:0] expv(input logic c_act, input logic d_act);
        return {c_act ? chg_act_high : !chg_act_high,
                d_act ? dsg_act_high : !dsg_act_high,
                c_act | d_act};
    endfunction

    task automatic chk(input string req, input logic c_act, input logic d_act);
        logic [2:0] e, a;
        e = expv(c_act, d_act);
        a = {chg_out, dsg_out, fault_mode};
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s: {chg,dsg,mode} actual %b expected %b at %0t", req, a, e, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_inputs();
        ov_det = 0; ov_rec = 0; uv_det = 0; uv_rec = 0;
        ow_det = 0; ow_rec = 0; ot_det = 0; ot_rec = 0;
        osc_bad = 0; test_req = 0; latch_en = 0; ms_tick = 1;
        fault_en = 5'b11111;
        ov_dly_sel = 0; uv_dly_sel = 0; ow_dly_sel = 0; ot_dly_sel = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_inputs();
        rst_n = 0;
        wait_n(2);
        rst_n = 1;
        wait_n(1);
    endtask

    task automatic t_reset_r12();
        @(negedge clk);
        rst_n = 0;
        wait_n(1);
        chk("R12 during reset", 0, 0);
        rst_n = 1;
        wait_n(1);
        chk("R12 after reset", 0, 0);
    endtask

    task automatic t_ov_delay_r1();
        do_reset();
        ov_det = 1;
        wait_n(250);
        chk("R1 OV before expiry", 0, 0);
        wait_n(1);
        chk("R1 OV expiry / R4 chg only / R10", 1, 0);
    endtask

    task automatic t_tick_gate_r1();
        do_reset();
        ms_tick = 0;
        ot_det = 1;
        wait_n(300);
        chk("R1 no ticks no progress", 0, 0);
        ms_tick = 1;
        wait_n(249);
        chk("R1 one tick short", 0, 0);
        wait_n(1);
        chk("R1 ticked expiry / R4 OT both", 1, 1);
    endtask

    task automatic t_sweep_r2();
        for (int s = 0; s < 6; s++) begin
            int lim;
            lim = (s >= 4) ? 4000 : (250 << s);
            do_reset();
            uv_dly_sel = 3'(s);
            uv_det = 1;
            wait_n(lim);
            chk($sformatf("R2 sel %0d before", s), 0, 0);
            wait_n(1);
            chk($sformatf("R2 sel %0d at delay / R4 UV dsg only", s), 0, 1);
        end
    endtask

    task automatic t_early_rec_r3();
        do_reset();
        ov_det = 1;
        wait_n(100);
        ov_det = 0; ov_rec = 1;
        wait_n(1);
        chk("R3 recovery cancels", 0, 0);
        ov_rec = 0; ov_det = 1;
        wait_n(250);
        chk("R3 full delay again", 0, 0);
        wait_n(1);
        chk("R3 declared after full delay", 1, 0);
    endtask

    task automatic t_ow_r4();
        do_reset();
        ow_det = 1;
        wait_n(251);
        chk("R4 OW both", 1, 1);
    endtask

    task automatic t_shared_r6();
        do_reset();
        ow_det = 1; uv_det = 1;
        wait_n(251);
        chk("R6 OW+UV declared", 1, 1);
        ow_det = 0; ow_rec = 1;
        wait_n(1);
        chk("R6 dsg held by UV after OW recovery", 0, 1);
        uv_det = 0; uv_rec = 1;
        wait_n(1);
        chk("R6 all recovered", 0, 0);
    endtask

    task automatic t_osc_r5();
        do_reset();
        osc_bad = 1;
        wait_n(1);
        chk("R5 osc immediate", 1, 1);
        osc_bad = 0;
        wait_n(1);
        chk("R5 osc clears", 0, 0);
    endtask

    task automatic t_latch_r7();
        do_reset();
        latch_en = 1;
        ov_det = 1;
        wait_n(251);
        chk("R7 latched declare", 1, 0);
        ov_det = 0; ov_rec = 1;
        wait_n(20);
        chk("R7 recovery ignored", 1, 0);
        osc_bad = 1;
        wait_n(1);
        osc_bad = 0;
        wait_n(5);
        chk("R7 osc latched", 1, 1);
        @(negedge clk);
        rst_n = 0;
        wait_n(1);
        rst_n = 1;
        wait_n(1);
        chk("R7 reset clears latch", 0, 0);
    endtask

    task automatic t_polarity_r8();
        do_reset();
        chg_act_high = 0; dsg_act_high = 1;
        wait_n(1);
        chk("R8 inverted idle levels", 0, 0);
        if (chg_out !== 1'b1 || dsg_out !== 1'b0) begin
            errors++;
            $display("FAIL R8 idle pins actual %b%b expected 10", chg_out, dsg_out);
        end
        checks++;
        uv_det = 1;
        wait_n(251);
        chk("R8 inverted active", 0, 1);
        chg_act_high = 1; dsg_act_high = 0;
        wait_n(1);
    endtask

    task automatic t_test_mode_r9();
        do_reset();
        test_req = 1;
        ot_dly_sel = 3'd4;
        wait_n(2);
        ot_det = 1;
        wait_n(50);
        chk("R9 test delay before", 0, 0);
        wait_n(1);
        chk("R9 test delay expiry", 1, 1);
        ot_det = 0; ot_rec = 1; test_req = 0;
        wait_n(2);
        ot_rec = 0;
        ov_det = 1;
        wait_n(60);
        chk("R9 left test mode", 0, 0);
        wait_n(191);
        chk("R9 normal delay restored", 1, 0);
    endtask

    task automatic t_enable_r11();
        do_reset();
        fault_en = 5'b11110;
        ov_det = 1;
        wait_n(300);
        chk("R11 OV disabled", 0, 0);
        fault_en = 5'b01111;
        osc_bad = 1;
        wait_n(3);
        chk("R11 osc disabled", 0, 0);
        osc_bad = 0;
        fault_en = 5'b11111;
        wait_n(251);
        chk("R11 OV re-enabled runs full delay", 1, 0);
    endtask

    initial begin
        t_reset_r12();
        t_ov_delay_r1();
        t_tick_gate_r1();
        t_sweep_r2();
        t_early_rec_r3();
        t_ow_r4();
        t_shared_r6();
        t_osc_r5();
        t_latch_r7();
        t_polarity_r8();
        t_test_mode_r9();
        t_enable_r11();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule